// File: doc/BRIEF.md
# Capacitive Key Matrix Burst Scan Sequencer

This block produces all the digital timing needed to scan a 32-key capacitive touch matrix. The matrix has eight drive columns and four receive rows. Each key sits at one column/row crossing. For each key in turn the sequencer does four things. It opens the charge-clear switch on the shared sample capacitor. It then sends a burst of drive pulses on the key's column. Around every rising drive edge it opens the key's row gate. Finally it strobes the converter once the burst is over.

The number of pulses in a burst comes from a per-key gain table. This lets every key be tuned on its own. The row-gate dwell after each rising drive edge can be programmed down to a single clock. A complementary set of gate outputs lets the rows that are not selected be switched to ground.

Scanning runs while `enable` is high. The sequencer visits keys in a fixed order and wraps after the last key. On each wrap it flags the end of a frame. The analog switches, the converter and any touch decision are outside this block.

Top module: `kmx_burst_seq`

## Requirements
- R1: At most one bit of `x_drive` is ever high. While a key is pulsed, only bit `key_idx >> 2` (the column) is used.
- R2: At most one bit of `row_gate` is high, and only bit `key_idx & 3` (the row). `row_gate_n` is always the bitwise inverse of `row_gate`.
- R3: Every rising edge of the drive is preceded by exactly one cycle in which the row gate is already open and the drive is low.
- R4: The row gate stays open for `dwell` cycles counted from the first drive-high cycle, and a `dwell` of 0 acts as 1. The drive stays high for max(4, dwell+1) cycles, so it always falls after the gate has closed.
- R5: A burst has exactly `gain` pulses, where the gain for key k is `gain_tbl[3k+2:3k]`. Consecutive pulses are separated by 8 cycles with drive and gate low.
- R6: Each burst with nonzero gain begins with one idle cycle followed by 4 cycles of `cs_clear` high. The first gate-open cycle follows at once.
- R7: `adc_start` is high for exactly one cycle, the cycle directly after the last drive-high cycle of a burst.
- R8: A key with gain 0 takes one idle cycle and one skip cycle. During both, all drive, gate, clear and convert outputs stay low.
- R9: Keys are visited in the order 0,1,...,31,0 (key = column*4 + row, row fastest). `frame_done` is high for exactly one cycle: the first cycle of key 0 that follows key 31.
- R10: When `enable` is low at a key's idle cycle, the sequencer holds in idle on that key with all strobes low. It resumes that key once `enable` returns high.
- R11: While `rst` is high, `key_idx` is 0, all drive, gate and strobe outputs are low, and `row_gate_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows the next key to start |
| gain_tbl | input | 96 | Pulse count per key, 3 bits each, key k at bits 3k+2:3k |
| dwell | input | 4 | Gate-open cycles after the drive rise (0 treated as 1) |
| x_drive | output | 8 | Column drive lines |
| row_gate | output | 4 | Active-high row sample gates |
| row_gate_n | output | 4 | Inverted row gates for grounding unselected rows |
| cs_clear | output | 1 | Sample-capacitor clear switch control |
| adc_start | output | 1 | One-cycle convert request at burst end |
| key_idx | output | 5 | Index of the key being scanned |
| frame_done | output | 1 | One-cycle pulse on wrap from key 31 to key 0 |

## Verification
The gate closing and the drive falling compete for the same cycle once the dwell reaches the nominal drive width. The design has to stretch the drive so that it falls one cycle after the gate closes. The bench runs whole frames with dwell values of 1, 3, 9, 15 and 0, working out the stretched width arithmetically. At every cycle of every pulse it compares the gate and drive lines, so a drive that falls with the gate still open, or a gate that stays open too long, shows up at the cycle where it happens. A second overlap, the frame-end pulse falling on the idle cycle of key 0 right after a skipped key 31, is provoked through the gain patterns and judged on that cycle.

// File: rtl/kmx_pkg.sv
package kmx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CLR   = 3'd1,
        PH_SETUP = 3'd2,
        PH_XHI   = 3'd3,
        PH_GAP   = 3'd4,
        PH_CONV  = 3'd5,
        PH_SKIP  = 3'd6
    } phase_e;

    // Per-cycle command from the timing engine to the line decoder
    typedef struct packed {
        logic x_on;
        logic y_on;
        logic clr;
        logic conv;
    } drive_cmd_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        return max2(max2(a, b), max2(c, d));
    endfunction

endpackage

// File: rtl/kmx_key_cursor.sv
module kmx_key_cursor
    import kmx_pkg::*;
#(
    parameter int NUM_KEYS = 32,
    parameter int GAIN_W   = 3,
    localparam int KEY_W   = $clog2(NUM_KEYS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       advance,
    input  logic [NUM_KEYS*GAIN_W-1:0] gain_tbl,
    output logic [KEY_W-1:0]           key_idx,
    output logic [GAIN_W-1:0]          key_gain,
    output logic                       frame_done
);

    localparam logic [KEY_W-1:0] LAST_KEY = KEY_W'(NUM_KEYS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_idx    <= '0;
            frame_done <= 1'b0;
        end else if (advance) begin
            if (key_idx == LAST_KEY) begin
                key_idx    <= '0;
                frame_done <= 1'b1;
            end else begin
                key_idx    <= key_idx + 1'b1;
                frame_done <= 1'b0;
            end
        end else begin
            frame_done <= 1'b0;
        end
    end

    always_comb key_gain = gain_tbl[int'(key_idx)*GAIN_W +: GAIN_W];

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (key_idx == '0)); // R9

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R9

endmodule

// File: rtl/kmx_phase_fsm.sv
module kmx_phase_fsm
    import kmx_pkg::*;
#(
    parameter int GAIN_W    = 3,
    parameter int DWELL_W   = 4,
    parameter int SETUP_CYC = 1,
    parameter int XHIGH_CYC = 4,
    parameter int GAP_CYC   = 8,
    parameter int CLR_CYC   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [GAIN_W-1:0]  gain,
    input  logic [DWELL_W-1:0] dwell,
    output drive_cmd_t         cmd,
    output logic               advance
);

    localparam int MAXC  = max4(2**DWELL_W, GAP_CYC, CLR_CYC, max2(XHIGH_CYC, SETUP_CYC));
    localparam int CNT_W = $clog2(MAXC + 1);

    phase_e             ph;
    logic [CNT_W-1:0]   cnt;
    logic [GAIN_W-1:0]  pcnt;
    logic [GAIN_W-1:0]  gain_q;
    logic [DWELL_W-1:0] dwell_q;
    logic [DWELL_W-1:0] dwell_eff;
    logic [CNT_W-1:0]   hi_len;
    logic [CNT_W-1:0]   dw_plus;

    always_comb begin
        dwell_eff = (dwell == '0) ? DWELL_W'(1) : dwell;
        dw_plus   = CNT_W'(dwell_q) + CNT_W'(1);
        hi_len    = (dw_plus > CNT_W'(XHIGH_CYC)) ? dw_plus : CNT_W'(XHIGH_CYC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            pcnt    <= '0;
            gain_q  <= '0;
            dwell_q <= DWELL_W'(1);
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (enable) begin
                        gain_q  <= gain;
                        dwell_q <= dwell_eff;
                        cnt     <= '0;
                        pcnt    <= '0;
                        ph      <= (gain == '0) ? PH_SKIP : PH_CLR;
                    end
                end
                PH_CLR: begin
                    if (cnt == CNT_W'(CLR_CYC - 1)) begin
                        cnt <= '0;
                        ph  <= PH_SETUP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (cnt == CNT_W'(SETUP_CYC - 1)) begin
                        cnt <= '0;
                        ph  <= PH_XHI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_XHI: begin
                    if (cnt == hi_len - CNT_W'(1)) begin
                        cnt  <= '0;
                        pcnt <= pcnt + 1'b1;
                        ph   <= (pcnt == gain_q - GAIN_W'(1)) ? PH_CONV : PH_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt == CNT_W'(GAP_CYC - 1)) begin
                        cnt <= '0;
                        ph  <= PH_SETUP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CONV: ph <= PH_IDLE;
                PH_SKIP: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd.x_on = (ph == PH_XHI);
        cmd.y_on = (ph == PH_SETUP) || ((ph == PH_XHI) && (cnt < CNT_W'(dwell_q)));
        cmd.clr  = (ph == PH_CLR);
        cmd.conv = (ph == PH_CONV);
        advance  = (ph == PH_CONV) || (ph == PH_SKIP);
    end

    AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd.conv |=> !cmd.conv); // R7

    AST_CONV_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd.conv |-> $past(cmd.x_on)); // R7

    AST_CLR_NO_GATE: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |-> (!cmd.x_on && !cmd.y_on)); // R6

endmodule

// File: rtl/kmx_line_drive.sv
module kmx_line_drive
    import kmx_pkg::*;
#(
    parameter int NUM_X  = 8,
    parameter int NUM_Y  = 4,
    localparam int XB    = $clog2(NUM_X),
    localparam int YB    = $clog2(NUM_Y),
    localparam int KEY_W = XB + YB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] key_idx,
    input  drive_cmd_t       cmd,
    output logic [NUM_X-1:0] x_drive,
    output logic [NUM_Y-1:0] row_gate,
    output logic [NUM_Y-1:0] row_gate_n,
    output logic             cs_clear,
    output logic             adc_start
);

    logic [XB-1:0] x_sel;
    logic [YB-1:0] y_sel;

    always_comb begin
        x_sel = key_idx[KEY_W-1:YB];
        y_sel = key_idx[YB-1:0];
    end

    for (genvar gx = 0; gx < NUM_X; gx++) begin : g_xcol
        assign x_drive[gx] = cmd.x_on && (x_sel == XB'(gx));
    end

    for (genvar gy = 0; gy < NUM_Y; gy++) begin : g_yrow
        assign row_gate[gy]   = cmd.y_on && (y_sel == YB'(gy));
        assign row_gate_n[gy] = !(cmd.y_on && (y_sel == YB'(gy)));
    end

    assign cs_clear  = cmd.clr;
    assign adc_start = cmd.conv;

    AST_X_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(x_drive)); // R1

    AST_Y_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_gate)); // R2

    AST_X_RISE_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(|x_drive) |-> ($past(|row_gate) && (|row_gate || !(|row_gate)))); // R3

    AST_X_FALL_CLOSED: assert property (@(posedge clk) disable iff (rst)
        $fell(|x_drive) |-> (row_gate == '0)); // R4

endmodule

// File: rtl/kmx_burst_seq.sv
module kmx_burst_seq
    import kmx_pkg::*;
#(
    parameter int NUM_X     = 8,
    parameter int NUM_Y     = 4,
    parameter int GAIN_W    = 3,
    parameter int DWELL_W   = 4,
    parameter int SETUP_CYC = 1,
    parameter int XHIGH_CYC = 4,
    parameter int GAP_CYC   = 8,
    parameter int CLR_CYC   = 4,
    localparam int NUM_KEYS = NUM_X * NUM_Y,
    localparam int KEY_W    = $clog2(NUM_KEYS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic [NUM_KEYS*GAIN_W-1:0] gain_tbl,
    input  logic [DWELL_W-1:0]         dwell,
    output logic [NUM_X-1:0]           x_drive,
    output logic [NUM_Y-1:0]           row_gate,
    output logic [NUM_Y-1:0]           row_gate_n,
    output logic                       cs_clear,
    output logic                       adc_start,
    output logic [KEY_W-1:0]           key_idx,
    output logic                       frame_done
);

    logic              advance;
    logic [GAIN_W-1:0] key_gain;
    drive_cmd_t        cmd;

    kmx_key_cursor #(
        .NUM_KEYS (NUM_KEYS),
        .GAIN_W   (GAIN_W)
    ) cursor_i (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .gain_tbl   (gain_tbl),
        .key_idx    (key_idx),
        .key_gain   (key_gain),
        .frame_done (frame_done)
    );

    kmx_phase_fsm #(
        .GAIN_W    (GAIN_W),
        .DWELL_W   (DWELL_W),
        .SETUP_CYC (SETUP_CYC),
        .XHIGH_CYC (XHIGH_CYC),
        .GAP_CYC   (GAP_CYC),
        .CLR_CYC   (CLR_CYC)
    ) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .gain    (key_gain),
        .dwell   (dwell),
        .cmd     (cmd),
        .advance (advance)
    );

    kmx_line_drive #(
        .NUM_X (NUM_X),
        .NUM_Y (NUM_Y)
    ) lines_i (
        .clk        (clk),
        .rst        (rst),
        .key_idx    (key_idx),
        .cmd        (cmd),
        .x_drive    (x_drive),
        .row_gate   (row_gate),
        .row_gate_n (row_gate_n),
        .cs_clear   (cs_clear),
        .adc_start  (adc_start)
    );

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(cs_clear && adc_start) && !(cs_clear && (|x_drive))); // R6

endmodule

// File: tb/kmx_burst_seq_tb_top.sv
module kmx_burst_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic [95:0] gain_tbl = '0;
    logic [3:0]  dwell = 4'd1;
    logic [7:0]  x_drive;
    logic [3:0]  row_gate;
    logic [3:0]  row_gate_n;
    logic        cs_clear;
    logic        adc_start;
    logic [4:0]  key_idx;
    logic        frame_done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    kmx_burst_seq dut_i (
        .clk(clk), .rst(rst), .enable(enable), .gain_tbl(gain_tbl), .dwell(dwell),
        .x_drive(x_drive), .row_gate(row_gate), .row_gate_n(row_gate_n),
        .cs_clear(cs_clear), .adc_start(adc_start), .key_idx(key_idx),
        .frame_done(frame_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual cycles %0d expected < 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic int gain_of(input int f, input int k);
        case (f)
            0: return k % 8;
            1: return (3 * k + 1) % 8;
            2: return k % 3;
            3: return 7 - (k % 8);
            default: return k % 2;
        endcase
    endfunction

    function automatic int dwell_of(input int f);
        case (f)
            0: return 1;
            1: return 3;
            2: return 9;
            3: return 0;
            default: return 15;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] xe, input logic [3:0] ye, input logic ce,
                       input logic ae, input logic [4:0] ke, input logic fe,
                       input string tag);
        checks++;
        if (x_drive !== xe || row_gate !== ye || row_gate_n !== ~ye || cs_clear !== ce ||
            adc_start !== ae || key_idx !== ke || frame_done !== fe) begin
            fails++;
            $display("FAIL %s t=%0t actual x=%b y=%b yn=%b clr=%b adc=%b key=%0d fd=%b expected x=%b y=%b yn=%b clr=%b adc=%b key=%0d fd=%b",
                     tag, $time, x_drive, row_gate, row_gate_n, cs_clear, adc_start, key_idx,
                     frame_done, xe, ye, ~ye, ce, ae, ke, fe);
        end
    endtask

    task automatic run_key(input int k, input int g, input int dw, input bit fd,
                           input bit pause);
        logic [7:0] xm;
        logic [3:0] ym;
        int dwe, hi;
        xm  = 8'(1 << (k / 4));
        ym  = 4'(1 << (k % 4));
        dwe = (dw == 0) ? 1 : dw;
        hi  = (dwe + 1 > 4) ? dwe + 1 : 4;
        chk('0, '0, 0, 0, 5'(k), fd, "R9 idle");
        if (pause) begin
            enable = 1'b0;
            for (int i = 0; i < 4; i++) begin
                step();
                chk('0, '0, 0, 0, 5'(k), 0, "R10 hold");
            end
            enable = 1'b1;
        end
        step();
        if (g == 0) begin
            chk('0, '0, 0, 0, 5'(k), 0, "R8 skip");
            step();
            return;
        end
        for (int i = 0; i < 4; i++) begin
            chk('0, '0, 1, 0, 5'(k), 0, "R6 clear");
            step();
        end
        for (int p = 0; p < g; p++) begin
            chk('0, ym, 0, 0, 5'(k), 0, "R2 R3 setup");
            step();
            for (int c = 0; c < hi; c++) begin
                chk(xm, (c < dwe) ? ym : 4'b0, 0, 0, 5'(k), 0, "R1 R4 pulse");
                step();
            end
            if (p < g - 1) begin
                for (int i = 0; i < 8; i++) begin
                    chk('0, '0, 0, 0, 5'(k), 0, "R5 gap");
                    step();
                end
            end
        end
        chk('0, '0, 0, 1, 5'(k), 0, "R7 convert");
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk('0, '0, 0, 0, 5'd0, 0, "R11 reset");
        step();
        chk('0, '0, 0, 0, 5'd0, 0, "R11 reset");
        rst = 1'b0;
        for (int f = 0; f < 5; f++) begin
            for (int k = 0; k < 32; k++) gain_tbl[k*3 +: 3] = 3'(gain_of(f, k));
            dwell = 4'(dwell_of(f));
            for (int k = 0; k < 32; k++) begin
                run_key(k, gain_of(f, k), dwell_of(f), (k == 0 && f != 0),
                        (f == 1 && k == 6) || (f == 3 && k == 31));
            end
        end
        // Wrap after the last frame: key 0 idle with frame pulse
        gain_tbl = '0;
        run_key(0, 0, 1, 1'b1, 1'b0);
        chk('0, '0, 0, 0, 5'd1, 0, "R9 after wrap");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule